// File: doc/BRIEF.md
# Memory Array Supply Switch Sequencer

This block moves the supply of on-chip memory arrays between two power rails: the core rail and a shared memory rail. A one-cycle request naming the target rail starts a fixed, ordered sequence of register writes and status reads. Each step goes out on a simple single-beat write port or read port, and every access waits for its acknowledge before the next one is issued. The registers it touches are the supply mux mode register, the supply mux status register, a cluster clock source mux, two cluster PLL control registers and a bank of power-manager event registers.

On older silicon, where the version input is below 0x1002_0000, the switch is wrapped in extra steps. Before the switch, the event lines are dropped, the block waits a short time and the clocks move to a safe source. After the switch, the clocks are restored and the events are re-armed, and the order of these two groups depends on the direction of the switch. Newer silicon needs only the mode write and the status poll. A divider produces a 1 us tick from the clock frequency parameter, and this tick paces both the settle wait and the status polling.

The block reports each completed switch with a one-cycle done pulse. A switch whose status never reports completion ends with a one-cycle timeout pulse. The selected rail is always visible on an output.

Top module: `array_rail_sequencer`

## Requirements
- R1: After reset the block is idle: busy, done and timeout are low, no write or read strobe is issued, and cur_rail reads 0 (core rail; the memory rail is 1).
- R2: req_valid is accepted only while busy is low. busy stays high from the cycle after acceptance until the sequence ends. A request made while busy is ignored and starts no later sequence.
- R3: On older silicon (hw_version < 0x1002_0000) the sequence begins in this order. Value 0 is written to the six event registers at 0x040 + 4*i, for i = 0 to 5 in ascending order. Then the block waits at least 2 us (2*CLK_MHZ cycles). Then 0x13 is written to the clock mux at 0x020, and 0xB0 to PLL0 at 0x030 and to PLL1 at 0x034.
- R4: The mode register at 0x010 is written 0x00 to select the memory rail or 0x10 to select the core rail.
- R5: Status at 0x014 is read, masked with 0x0F and compared with 0x0 (memory rail) or 0x3 (core rail). Successive reads are spaced at least 1 us apart.
- R6: When 10 reads pass without a match, the block pulses timeout instead of done and cur_rail keeps its old value. The post-switch steps still run.
- R7: On older silicon, a switch to the memory rail ends by restoring the clocks (0x03 to the clock mux, then 0x30 to PLL0 and PLL1) and then writing 1 to the six event registers in ascending order.
- R8: On older silicon, a switch to the core rail ends by re-arming the events first and restoring the clocks second, using the same values as R7.
- R9: On newer silicon (hw_version >= 0x1002_0000) the only accesses are the mode write and the status reads.
- R10: At most one write is outstanding at a time, and write and read strobes never coincide.
- R11: done and timeout are one-cycle pulses that never occur together. cur_rail changes only with done, and in the cycle done is high it already shows the new rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle switch request |
| req_rail | input | 1 | Target rail: 0 core, 1 memory |
| hw_version | input | 32 | Silicon version value, static |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_ack | input | 1 | Write acknowledge |
| rd_stb | output | 1 | One-cycle read strobe |
| rd_addr | output | AW | Read address (status) |
| rd_data | input | DW | Read data, valid with rd_ack |
| rd_ack | input | 1 | Read acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Switch completed pulse |
| timeout | output | 1 | Switch timed out pulse |
| cur_rail | output | 1 | Rail currently selected |

## Verification
The bench logs every write in order, so it catches two kinds of error: post-switch groups run in the same order for both directions, and old-silicon steps that leak into the newer-revision path. The status model sets bit 4 and the upper bits of the status word. A design that masked with 0x1F, or compared the whole word, would therefore never see completion. One run is built so the status never matches. It checks that exactly ten spaced reads take place, that the timeout pulse fires, and that the rail is left alone. A design that updated the rail anyway, or skipped the clock restore, would be flagged. A request made in the middle of a run must not start a second sequence. A hit at exactly 0x1002_0000 must count as a new revision.

// File: rtl/rail_seq_pkg.sv
// Shared state encoding and fixed register values for the rail sequencer.
// Assumes: values are byte wide and zero-extended onto the data bus.
package rail_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EVT_CLR,
        ST_SETTLE,
        ST_CLK_OVR,
        ST_MODE,
        ST_POLL,
        ST_GAP,
        ST_CLK_RST,
        ST_EVT_SET,
        ST_FINISH
    } seq_state_t;

    localparam logic RAIL_CORE = 1'b0;
    localparam logic RAIL_MEM  = 1'b1;

    localparam logic [7:0] MUX_SAFE_VAL    = 8'h13;
    localparam logic [7:0] MUX_NORMAL_VAL  = 8'h03;
    localparam logic [7:0] PLL_SAFE_VAL    = 8'hB0;
    localparam logic [7:0] PLL_NORMAL_VAL  = 8'h30;
    localparam logic [7:0] MODE_MEM_VAL    = 8'h00;
    localparam logic [7:0] MODE_CORE_VAL   = 8'h10;
    localparam logic [7:0] STS_MASK        = 8'h0F;
    localparam logic [7:0] STS_MEM_DONE    = 8'h00;
    localparam logic [7:0] STS_CORE_DONE   = 8'h03;
    localparam logic [7:0] EVT_LOW_VAL     = 8'h00;
    localparam logic [7:0] EVT_HIGH_VAL    = 8'h01;

endpackage

// File: rtl/rail_us_timer.sv
// Microsecond timer: after start it counts us_count periods of CLK_MHZ
// cycles and then pulses expired for one cycle.
// Assumes: CLK_MHZ >= 2 and us_count >= 1; a new start restarts the count.
module rail_us_timer #(
    parameter int CLK_MHZ = 250,
    parameter int CNT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] us_count,
    output logic             expired
);
    localparam int DIV_W = $clog2(CLK_MHZ + 1);
    localparam logic [DIV_W-1:0] DIV_LOAD = DIV_W'(CLK_MHZ - 1);

    logic             running;
    logic [DIV_W-1:0] div_cnt;
    logic [CNT_W-1:0] us_left;

    // Cycle divider and microsecond countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            div_cnt <= '0;
            us_left <= '0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (start) begin
                running <= 1'b1;
                div_cnt <= DIV_LOAD;
                us_left <= us_count;
            end else if (running) begin
                if (div_cnt == '0) begin
                    div_cnt <= DIV_LOAD;
                    if (us_left == CNT_W'(1)) begin
                        running <= 1'b0;
                        expired <= 1'b1;
                    end else begin
                        us_left <= us_left - CNT_W'(1);
                    end
                end else begin
                    div_cnt <= div_cnt - DIV_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rail_write_table.sv
// Write step table: maps the current write phase and step index to the
// address and data of the access, and flags the last step of the phase.
// Assumes: only queried in write phases; clock phases have three steps.
module rail_write_table
    import rail_seq_pkg::*;
#(
    parameter int            AW         = 12,
    parameter int            DW         = 32,
    parameter int            IDX_W      = 3,
    parameter int            NUM_EVENTS = 6,
    parameter logic [AW-1:0] MODE_ADDR  = 12'h010,
    parameter logic [AW-1:0] CMUX_ADDR  = 12'h020,
    parameter logic [AW-1:0] PLL0_ADDR  = 12'h030,
    parameter logic [AW-1:0] PLL1_ADDR  = 12'h034,
    parameter logic [AW-1:0] EVT_BASE   = 12'h040,
    parameter int            EVT_STRIDE = 4
) (
    input  seq_state_t       phase,
    input  logic [IDX_W-1:0] idx,
    input  logic             target,
    output logic [AW-1:0]    addr,
    output logic [DW-1:0]    data,
    output logic             last
);
    // Decode phase and index into one bus access.
    always_comb begin
        addr = '0;
        data = '0;
        last = 1'b1;
        case (phase)
            ST_EVT_CLR, ST_EVT_SET: begin
                addr = EVT_BASE + AW'(idx) * AW'(EVT_STRIDE);
                data = (phase == ST_EVT_SET) ? DW'(EVT_HIGH_VAL) : DW'(EVT_LOW_VAL);
                last = (idx == IDX_W'(NUM_EVENTS - 1));
            end
            ST_CLK_OVR, ST_CLK_RST: begin
                last = (idx == IDX_W'(2));
                if (idx == '0) begin
                    addr = CMUX_ADDR;
                    data = (phase == ST_CLK_OVR) ? DW'(MUX_SAFE_VAL) : DW'(MUX_NORMAL_VAL);
                end else begin
                    addr = (idx == IDX_W'(1)) ? PLL0_ADDR : PLL1_ADDR;
                    data = (phase == ST_CLK_OVR) ? DW'(PLL_SAFE_VAL) : DW'(PLL_NORMAL_VAL);
                end
            end
            ST_MODE: begin
                addr = MODE_ADDR;
                data = (target == RAIL_MEM) ? DW'(MODE_MEM_VAL) : DW'(MODE_CORE_VAL);
            end
            default: begin
                addr = '0;
                data = '0;
                last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/array_rail_sequencer.sv
// Memory array supply switch sequencer. Accepts a rail request while idle,
// runs the revision-dependent write/poll sequence over single-beat write
// and read ports, and reports done or timeout with the selected rail.
// Assumes: acknowledges arrive at least one cycle after their strobe;
// hw_version is static while a sequence runs.
module array_rail_sequencer
    import rail_seq_pkg::*;
#(
    parameter int            CLK_MHZ       = 250,
    parameter int            AW            = 12,
    parameter int            DW            = 32,
    parameter int            NUM_EVENTS    = 6,
    parameter int            SETTLE_US     = 2,
    parameter int            POLL_BUDGET   = 10,
    parameter logic [31:0]   LEGACY_LIMIT  = 32'h1002_0000,
    parameter logic [AW-1:0] MODE_ADDR     = 12'h010,
    parameter logic [AW-1:0] STAT_ADDR     = 12'h014,
    parameter logic [AW-1:0] CMUX_ADDR     = 12'h020,
    parameter logic [AW-1:0] PLL0_ADDR     = 12'h030,
    parameter logic [AW-1:0] PLL1_ADDR     = 12'h034,
    parameter logic [AW-1:0] EVT_BASE      = 12'h040,
    parameter int            EVT_STRIDE    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_rail,
    input  logic [31:0]   hw_version,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ack,
    output logic          rd_stb,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_ack,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic          cur_rail
);
    localparam int IDX_W = (NUM_EVENTS > 4) ? $clog2(NUM_EVENTS) : 2;
    localparam int PW    = $clog2(POLL_BUDGET + 1);
    localparam int TW    = $clog2(((SETTLE_US > 1) ? SETTLE_US : 1) + 1);

    seq_state_t       state;
    seq_state_t       after_write;
    seq_state_t       post_state;
    logic [IDX_W-1:0] idx;
    logic             target;
    logic             legacy;
    logic             tmo_flag;
    logic [PW-1:0]    polls_left;
    logic             wr_wait;
    logic             rd_wait;
    logic             cur_rail_q;
    logic             done_q;
    logic             tmo_q;
    logic             tbl_last;
    logic             is_wr_phase;
    logic             sts_hit;
    logic             is_legacy;
    logic             tmr_start;
    logic [TW-1:0]    tmr_count;
    logic             tmr_expired;

    rail_write_table #(
        .AW(AW), .DW(DW), .IDX_W(IDX_W), .NUM_EVENTS(NUM_EVENTS),
        .MODE_ADDR(MODE_ADDR), .CMUX_ADDR(CMUX_ADDR), .PLL0_ADDR(PLL0_ADDR),
        .PLL1_ADDR(PLL1_ADDR), .EVT_BASE(EVT_BASE), .EVT_STRIDE(EVT_STRIDE)
    ) u_table (
        .phase (state),
        .idx   (idx),
        .target(target),
        .addr  (wr_addr),
        .data  (wr_data),
        .last  (tbl_last)
    );

    rail_us_timer #(.CLK_MHZ(CLK_MHZ), .CNT_W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .us_count(tmr_count),
        .expired (tmr_expired)
    );

    // Strobes, status match and revision decode.
    always_comb begin
        is_wr_phase = (state == ST_EVT_CLR) || (state == ST_CLK_OVR) || (state == ST_MODE)
                   || (state == ST_CLK_RST) || (state == ST_EVT_SET);
        wr_stb    = is_wr_phase && !wr_wait;
        rd_stb    = (state == ST_POLL) && !rd_wait;
        rd_addr   = STAT_ADDR;
        sts_hit   = (rd_data & DW'(STS_MASK))
                 == DW'((target == RAIL_MEM) ? STS_MEM_DONE : STS_CORE_DONE);
        is_legacy = (hw_version < LEGACY_LIMIT);
        tmr_start = ((state == ST_EVT_CLR) && wr_wait && wr_ack && tbl_last)
                 || ((state == ST_POLL) && rd_wait && rd_ack && !sts_hit
                     && (polls_left != PW'(1)));
        tmr_count = (state == ST_EVT_CLR) ? TW'(SETTLE_US) : TW'(1);
    end

    // Phase that follows the last write of the current phase, and the
    // first phase after polling; the post-switch order depends on direction.
    always_comb begin
        case (state)
            ST_EVT_CLR: after_write = ST_SETTLE;
            ST_CLK_OVR: after_write = ST_MODE;
            ST_MODE:    after_write = ST_POLL;
            ST_CLK_RST: after_write = (target == RAIL_MEM) ? ST_EVT_SET : ST_FINISH;
            ST_EVT_SET: after_write = (target == RAIL_MEM) ? ST_FINISH : ST_CLK_RST;
            default:    after_write = ST_IDLE;
        endcase
        if (!legacy)
            post_state = ST_FINISH;
        else
            post_state = (target == RAIL_MEM) ? ST_CLK_RST : ST_EVT_SET;
    end

    // Sequencer state, access handshakes, poll budget and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            idx        <= '0;
            target     <= RAIL_CORE;
            legacy     <= 1'b0;
            tmo_flag   <= 1'b0;
            polls_left <= '0;
            wr_wait    <= 1'b0;
            rd_wait    <= 1'b0;
            cur_rail_q <= RAIL_CORE;
            done_q     <= 1'b0;
            tmo_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        target   <= req_rail;
                        legacy   <= is_legacy;
                        tmo_flag <= 1'b0;
                        idx      <= '0;
                        state    <= is_legacy ? ST_EVT_CLR : ST_MODE;
                    end
                end
                ST_EVT_CLR, ST_CLK_OVR, ST_MODE, ST_CLK_RST, ST_EVT_SET: begin
                    if (!wr_wait) begin
                        wr_wait <= 1'b1;
                    end else if (wr_ack) begin
                        wr_wait <= 1'b0;
                        if (!tbl_last) begin
                            idx <= idx + IDX_W'(1);
                        end else begin
                            idx   <= '0;
                            state <= after_write;
                            if (state == ST_MODE)
                                polls_left <= PW'(POLL_BUDGET);
                        end
                    end
                end
                ST_SETTLE: begin
                    if (tmr_expired)
                        state <= ST_CLK_OVR;
                end
                ST_POLL: begin
                    if (!rd_wait) begin
                        rd_wait <= 1'b1;
                    end else if (rd_ack) begin
                        rd_wait <= 1'b0;
                        if (sts_hit) begin
                            state <= post_state;
                        end else if (polls_left == PW'(1)) begin
                            tmo_flag <= 1'b1;
                            state    <= post_state;
                        end else begin
                            polls_left <= polls_left - PW'(1);
                            state      <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (tmr_expired)
                        state <= ST_POLL;
                end
                ST_FINISH: begin
                    done_q <= !tmo_flag;
                    tmo_q  <= tmo_flag;
                    if (!tmo_flag)
                        cur_rail_q <= target;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign timeout  = tmo_q;
    assign cur_rail = cur_rail_q;

endmodule

// File: rtl/rail_seq_checker.sv
// Protocol checker for the rail sequencer, bound to every instance.
// Assumes: acknowledges never arrive in the cycle of their own strobe.
module rail_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic timeout,
    input logic cur_rail,
    input logic wr_stb,
    input logic wr_ack,
    input logic rd_stb
);
    logic wr_out;

    // Track an outstanding write independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_out <= 1'b0;
        else if (wr_stb)
            wr_out <= 1'b1;
        else if (wr_ack)
            wr_out <= 1'b0;
    end

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(wr_stb || rd_stb));
    assert_end_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout) |-> !busy);
    assert_rail_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $stable(cur_rail));
    assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !wr_out);
    assert_bus_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb));
    assert_end_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, timeout}));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_rail_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(cur_rail));

endmodule

bind array_rail_sequencer rail_seq_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .timeout (timeout),
    .cur_rail(cur_rail),
    .wr_stb  (wr_stb),
    .wr_ack  (wr_ack),
    .rd_stb  (rd_stb)
);

// File: tb/array_rail_sequencer_bench.sv
`timescale 1ns/1ps
module array_rail_sequencer_bench;
    localparam int CLK_MHZ = 250;
    localparam logic [11:0] A_MODE = 12'h010;
    localparam logic [11:0] A_STAT = 12'h014;
    localparam logic [11:0] A_CMUX = 12'h020;
    localparam logic [11:0] A_PLL0 = 12'h030;
    localparam logic [11:0] A_PLL1 = 12'h034;
    localparam logic [11:0] A_EVT  = 12'h040;
    localparam logic [31:0] V_OLD  = 32'h1001_FFFF;
    localparam logic [31:0] V_NEW  = 32'h1002_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_rail = 1'b0;
    logic [31:0] hw_version = V_OLD;
    logic        wr_stb, rd_stb, busy, done, timeout, cur_rail;
    logic [11:0] wr_addr, rd_addr;
    logic [31:0] wr_data;
    logic        wr_ack = 1'b0;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    array_rail_sequencer u_array_rail_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rail(req_rail),
        .hw_version(hw_version), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ack(wr_ack), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_ack(rd_ack), .busy(busy), .done(done),
        .timeout(timeout), .cur_rail(cur_rail)
    );

    // Bus model state and logs
    int          cyc = 0;
    int          wr_cnt = 0, rd_cnt = 0, overlap = 0;
    logic [11:0] log_addr [0:63];
    logic [31:0] log_data [0:63];
    int          log_cyc  [0:63];
    int          log_n = 0;
    int          rd_cyc   [0:31];
    int          rd_n = 0, bad_rd_addr = 0;
    bit          mode_seen = 0, never_ready = 0;
    int          ready_after = 0, since_mode = 0;
    logic [3:0]  goal = 4'h0;
    logic [31:0] rd_hold = '0;
    bit          seen_done = 0, seen_tmo = 0;
    int          done_cnt = 0;
    logic [11:0] exp_addr [0:63];
    logic [31:0] exp_data [0:63];
    int          exp_n = 0;

    // Responder: acknowledges two cycles after each strobe, models status.
    always @(negedge clk) begin
        cyc++;
        wr_ack = 1'b0;
        rd_ack = 1'b0;
        if (wr_cnt == 1) wr_ack = 1'b1;
        if (wr_cnt > 0) wr_cnt--;
        if (rd_cnt == 1) begin rd_ack = 1'b1; rd_data = rd_hold; end
        if (rd_cnt > 0) rd_cnt--;
        if (wr_stb) begin
            if (wr_cnt != 0 || rd_cnt != 0) overlap++;
            if (log_n < 64) begin
                log_addr[log_n] = wr_addr;
                log_data[log_n] = wr_data;
                log_cyc[log_n]  = cyc;
                log_n++;
            end
            wr_cnt = 2;
            if (wr_addr == A_MODE) begin
                mode_seen  = 1;
                since_mode = 0;
                goal = (wr_data == 32'h0) ? 4'h0 : 4'h3;
            end
        end
        if (rd_stb) begin
            if (wr_cnt != 0 || rd_cnt != 0 || wr_stb) overlap++;
            if (rd_addr != A_STAT) bad_rd_addr++;
            if (rd_n < 32) rd_cyc[rd_n] = cyc;
            rd_n++;
            rd_cnt = 2;
            rd_hold = {24'h5A5A5A, 4'hF,
                       (mode_seen && !never_ready && since_mode >= ready_after) ? goal : 4'h1};
            since_mode++;
        end
        if (done) begin seen_done = 1; done_cnt++; end
        if (timeout) seen_tmo = 1;
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        log_n = 0; rd_n = 0; mode_seen = 0; since_mode = 0;
        seen_done = 0; seen_tmo = 0; done_cnt = 0; exp_n = 0;
        overlap = 0; bad_rd_addr = 0;
    endtask

    task automatic push(input logic [11:0] a, input logic [31:0] d);
        exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
    endtask

    task automatic push_events(input logic [31:0] d);
        for (int i = 0; i < 6; i++) push(A_EVT + 12'(4 * i), d);
    endtask

    task automatic push_clocks(input bit safe);
        push(A_CMUX, safe ? 32'h13 : 32'h03);
        push(A_PLL0, safe ? 32'hB0 : 32'h30);
        push(A_PLL1, safe ? 32'hB0 : 32'h30);
    endtask

    // Expected write list built from R3, R4, R7, R8, R9.
    task automatic build_expected(input bit rail, input bit old_rev);
        if (old_rev) begin push_events(32'h0); push_clocks(1); end
        push(A_MODE, rail ? 32'h00 : 32'h10);
        if (old_rev) begin
            if (rail) begin push_clocks(0); push_events(32'h1); end
            else      begin push_events(32'h1); push_clocks(0); end
        end
    endtask

    task automatic compare_log(input bit old_rev, input string post_rq);
        string rq;
        check(log_n == exp_n, post_rq, "write count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (old_rev && i < 9) rq = "R3";
            else if ((old_rev && i == 9) || (!old_rev && i == 0)) rq = "R4";
            else rq = post_rq;
            check(log_addr[i] == exp_addr[i] && log_data[i] == exp_data[i], rq,
                  $sformatf("write %0d addr/data", i),
                  {log_addr[i], log_data[i]}, {exp_addr[i], exp_data[i]});
        end
    endtask

    task automatic start_req(input bit rail);
        @(negedge clk);
        req_valid = 1'b1; req_rail = rail;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end();
        int n = 0;
        while (!seen_done && !seen_tmo && n < 20000) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_bus_rules(input string tag);
        check(overlap == 0, "R10", {tag, " overlapping accesses"}, overlap, 0);
        check(bad_rd_addr == 0, "R5", {tag, " read address"}, bad_rd_addr, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!busy && !done && !timeout, "R1", "idle flags after reset",
              {busy, done, timeout}, 0);
        check(!wr_stb && !rd_stb, "R1", "strobes after reset", {wr_stb, rd_stb}, 0);
        check(cur_rail == 1'b0, "R1", "rail after reset", cur_rail, 0);
    endtask

    task automatic t_old_to_mem();
        clear_logs(); hw_version = V_OLD; ready_after = 3; never_ready = 0;
        build_expected(1, 1);
        start_req(1);
        check(busy, "R2", "busy after accept", busy, 1);
        wait_end();
        compare_log(1, "R7");
        if (log_n > 6)
            check(log_cyc[6] - log_cyc[5] >= 2 * CLK_MHZ, "R3", "settle wait cycles",
                  log_cyc[6] - log_cyc[5], 2 * CLK_MHZ);
        check(rd_n == 4, "R5", "status reads until match", rd_n, 4);
        for (int i = 0; i + 1 < rd_n && i < 31; i++)
            check(rd_cyc[i + 1] - rd_cyc[i] >= CLK_MHZ, "R5", "read spacing",
                  rd_cyc[i + 1] - rd_cyc[i], CLK_MHZ);
        check(seen_done && !seen_tmo, "R11", "done not timeout", {seen_done, seen_tmo}, 2'b10);
        check(done_cnt == 1, "R11", "done pulse width", done_cnt, 1);
        check(cur_rail == 1'b1 && !busy, "R11", "rail and busy after done", {cur_rail, busy}, 2'b10);
        check_bus_rules("old to memory");
    endtask

    task automatic t_old_to_core();
        clear_logs(); hw_version = V_OLD; ready_after = 0; never_ready = 0;
        build_expected(0, 1);
        start_req(0);
        wait_end();
        compare_log(1, "R8");
        check(rd_n == 1, "R5", "single read on immediate match", rd_n, 1);
        check(seen_done && cur_rail == 1'b0, "R8", "core rail selected", {seen_done, cur_rail}, 2'b10);
        check_bus_rules("old to core");
    endtask

    task automatic t_new_to_mem();
        clear_logs(); hw_version = V_NEW; ready_after = 1; never_ready = 0;
        build_expected(1, 0);
        start_req(1);
        wait_end();
        compare_log(0, "R9");
        check(rd_n == 2, "R9", "status reads new revision", rd_n, 2);
        check(seen_done && cur_rail == 1'b1, "R9", "memory rail selected", {seen_done, cur_rail}, 2'b11);
        check_bus_rules("new to memory");
    endtask

    task automatic t_timeout();
        clear_logs(); hw_version = V_OLD; never_ready = 1;
        build_expected(0, 1);
        start_req(0);
        wait_end();
        check(seen_tmo && !seen_done, "R6", "timeout not done", {seen_tmo, seen_done}, 2'b10);
        check(rd_n == 10, "R6", "reads before timeout", rd_n, 10);
        check(cur_rail == 1'b1, "R6", "rail unchanged", cur_rail, 1);
        compare_log(1, "R6");
        check_bus_rules("timeout");
        never_ready = 0;
    endtask

    task automatic t_busy_ignore();
        clear_logs(); hw_version = V_NEW; ready_after = 2; never_ready = 0;
        start_req(0);
        repeat (50) @(negedge clk);
        check(busy, "R2", "busy mid-sequence", busy, 1);
        req_valid = 1'b1; req_rail = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_end();
        check(log_n == 1 && log_data[0] == 32'h10, "R2", "only core-rail mode write",
              {log_n[7:0], log_data[0]}, {8'd1, 32'h10});
        check(rd_n == 3, "R2", "reads of first request only", rd_n, 3);
        repeat (30) @(negedge clk);
        check(!busy && log_n == 1, "R2", "ignored request stays ignored", {busy, log_n[7:0]}, 9'd1);
        check(cur_rail == 1'b0, "R2", "rail from accepted request", cur_rail, 0);
        check_bus_rules("busy ignore");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_old_to_mem();
        t_old_to_core();
        t_new_to_mem();
        t_timeout();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule